// File: doc/BRIEF.md
# Periodic Conversion-Start Sequencer with Auto-Nap

This block paces a successive-approximation analog core on its own. Every cycle is counted on the conversion clock. While auto-trigger is enabled, the block issues a one-cycle start strobe at the head of every sampling period. It holds the active-low end-of-conversion flag low while the core resolves its bits. When auto-nap is requested, it can also drop the core into a low-power state between conversions.

Each period opens with 3 acquisition cycles and then 18 conversion cycles, 21 cycles in all. A single select input picks either the fast period of 21 cycles or the slow period of 42 cycles. The slow period has idle cycles after the conversion, and the nap signal uses them. It is raised one cycle after the conversion finishes. It is released early enough that the core gets 3 wake-up cycles and then 3 acquisition cycles before the start strobe falls. The fast period has no idle cycles, so a nap request at that rate is ignored.

Top module: `sar_autotrig_seq`

## Requirements
- R1: With the fast rate in force (rate_slow_sel = 0), conv_start is high for exactly one cycle at cycle index 0 of each period, and consecutive strobes are 21 cycles apart.
- R2: With the slow rate in force (rate_slow_sel = 1), consecutive conv_start strobes are 42 cycles apart.
- R3: Within a period, eoc_n is low for cycle indices 3 to 20 inclusive, which are the 18 conversion cycles after the 3 acquisition cycles. It is high at every other index.
- R4: nap_active is high at cycle indices 22 to 36 inclusive when all of the following hold: the slow rate is in force, auto-trigger runs, and auto_nap_en is high in that same cycle. It is low at all other times, and it is never high together with conv_start or with eoc_n low.
- R5: In the slow rate with auto-nap, nap_active falls at cycle index 37, five cycles before the next conv_start. The strobe therefore falls six cycles after nap releases: 3 cycles of wake-up and 3 of acquisition.
- R6: While the fast rate is in force, an auto-nap request has no effect and nap_active stays low.
- R7: While auto_trig_en is low, the cycle count holds at zero, conv_start stays low, eoc_n stays high and nap_active stays low. After auto_trig_en is seen high at a clock edge, the first strobe appears in the cycle after that edge.
- R8: The value of rate_slow_sel is taken only at the start of a period, so a change part-way through a period does not shorten or stretch that period. The new rate governs the following period.
- R9: During reset and after its release, with auto-trigger off, conv_start is low, eoc_n is high and nap_active is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_conv | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| auto_trig_en | input | 1 | Runs the periodic sequencer when high |
| rate_slow_sel | input | 1 | 0 selects the 21-cycle period, 1 selects the 42-cycle period |
| auto_nap_en | input | 1 | Requests power-down of the core between conversions |
| conv_start | output | 1 | One-cycle conversion-start strobe |
| eoc_n | output | 1 | Active-low end-of-conversion flag, low during conversion cycles |
| nap_active | output | 1 | High to power down the analog core |

## Verification
A change of rate_slow_sel and the period-boundary reload of the latched rate can land in the same cycle. A request made in the last cycle of a period must win at once, but one made a cycle earlier must not cut that period short. The bench provokes this by flipping the rate at every one of the 42 cycle indices of a slow period, and again from the fast side. It judges each case by the spacing between successive strobes against the rate latched at the start of each period. Enable drops and auto-nap drops are swept over every index in the same way, so that they fall on the strobe, on the nap edges and on the conversion boundaries.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } rate_e;

  // Length of one sampling period for a given rate, in conversion-clock cycles.
  function automatic int unsigned period_cycles(rate_e r, int unsigned base);
    return (r == RATE_SLOW) ? 2 * base : base;
  endfunction

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stage_q;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    logic d;
    if (gi == 0) begin : g_first
      assign d = 1'b1;
    end else begin : g_next
      assign d = stage_q[gi-1];
    end
    always_ff @(posedge clk or negedge rst_async_n) begin
      if (!rst_async_n) stage_q[gi] <= 1'b0;
      else              stage_q[gi] <= d;
    end
  end

  assign rst_sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/sar_period_ctr.sv
module sar_period_ctr
  import sar_seq_pkg::*;
#(
  parameter int unsigned ACQ_CYC  = 3,
  parameter int unsigned CONV_CYC = 18,
  parameter int unsigned CW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_en,
  input  logic          rate_sel,
  output logic          run,
  output logic [CW-1:0] cnt,
  output rate_e         rate
);

  localparam int unsigned P_FAST    = ACQ_CYC + CONV_CYC;
  localparam int unsigned P_SLOW    = period_cycles(RATE_SLOW, P_FAST);
  localparam logic [CW-1:0] LAST_FAST = CW'(P_FAST - 1);
  localparam logic [CW-1:0] LAST_SLOW = CW'(P_SLOW - 1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  rate_e         rate_q, rate_d;
  logic          at_last;
  logic          ce;

  assign at_last = (cnt_q == ((rate_q == RATE_SLOW) ? LAST_SLOW : LAST_FAST));
  assign ce      = auto_en | run_q;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    rate_d = rate_q;
    if (!auto_en) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (!run_q) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      rate_d = rate_e'(rate_sel);
    end else if (at_last) begin
      cnt_d  = '0;
      rate_d = rate_e'(rate_sel);
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      rate_q <= RATE_FAST;
    end else if (ce) begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      rate_q <= rate_d;
    end
  end

  assign run  = run_q;
  assign cnt  = cnt_q;
  assign rate = rate_q;

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ((rate_q == RATE_SLOW) ? LAST_SLOW : LAST_FAST)); // R2
  AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0) |-> $stable(rate_q)); // R8
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (cnt_q == '0 && !run_q)); // R7

endmodule

// File: rtl/sar_phase_dec.sv
module sar_phase_dec
  import sar_seq_pkg::*;
#(
  parameter int unsigned ACQ_CYC  = 3,
  parameter int unsigned CONV_CYC = 18,
  parameter int unsigned WAKE_CYC = 3,
  parameter int unsigned CW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] cnt,
  input  rate_e         rate,
  input  logic          nap_req,
  output logic          start_stb,
  output logic          eoc_n,
  output logic          nap
);

  localparam int unsigned P_FAST   = ACQ_CYC + CONV_CYC;
  localparam int unsigned P_SLOW   = period_cycles(RATE_SLOW, P_FAST);
  localparam logic [CW-1:0] CONV_LO = CW'(ACQ_CYC);
  localparam logic [CW-1:0] CONV_HI = CW'(P_FAST - 1);
  localparam logic [CW-1:0] NAP_LO  = CW'(P_FAST + 1);
  localparam logic [CW-1:0] NAP_END = CW'(P_SLOW - WAKE_CYC - ACQ_CYC + 1);

  logic in_conv;
  logic in_nap_win;

  always_comb begin
    in_conv    = (cnt >= CONV_LO) && (cnt <= CONV_HI);
    in_nap_win = (cnt >= NAP_LO) && (cnt < NAP_END);
    start_stb  = run && (cnt == '0);
    eoc_n      = !(run && in_conv);
    nap        = run && nap_req && (rate == RATE_SLOW) && in_nap_win;
  end

  AST_START_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> !start_stb); // R1
  AST_EOC_AFTER_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_n) |-> (cnt == CONV_LO)); // R3
  AST_NAP_OUTSIDE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    nap |-> (eoc_n && !start_stb)); // R4
  AST_FAST_NEVER_NAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == RATE_FAST) |-> !nap); // R6
  AST_NAP_WAKE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nap) && nap_req && run) |-> (cnt == NAP_END)); // R5

endmodule

// File: rtl/sar_autotrig_seq.sv
module sar_autotrig_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned ACQ_CYC   = 3,
  parameter int unsigned CONV_CYC  = 18,
  parameter int unsigned WAKE_CYC  = 3,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic clk_conv,
  input  logic rst_n,
  input  logic auto_trig_en,
  input  logic rate_slow_sel,
  input  logic auto_nap_en,
  output logic conv_start,
  output logic eoc_n,
  output logic nap_active
);

  localparam int unsigned P_FAST = ACQ_CYC + CONV_CYC;
  localparam int unsigned P_SLOW = period_cycles(RATE_SLOW, P_FAST);
  localparam int unsigned CW     = $clog2(P_SLOW);

  logic          rst_s_n;
  logic          run;
  logic [CW-1:0] cnt;
  rate_e         rate;

  sar_rst_sync #(.STAGES(RST_STAGE)) u_rst_sync (
    .clk         (clk_conv),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_s_n)
  );

  sar_period_ctr #(
    .ACQ_CYC  (ACQ_CYC),
    .CONV_CYC (CONV_CYC),
    .CW       (CW)
  ) u_ctr (
    .clk      (clk_conv),
    .rst_n    (rst_s_n),
    .auto_en  (auto_trig_en),
    .rate_sel (rate_slow_sel),
    .run      (run),
    .cnt      (cnt),
    .rate     (rate)
  );

  sar_phase_dec #(
    .ACQ_CYC  (ACQ_CYC),
    .CONV_CYC (CONV_CYC),
    .WAKE_CYC (WAKE_CYC),
    .CW       (CW)
  ) u_dec (
    .clk       (clk_conv),
    .rst_n     (rst_s_n),
    .run       (run),
    .cnt       (cnt),
    .rate      (rate),
    .nap_req   (auto_nap_en),
    .start_stb (conv_start),
    .eoc_n     (eoc_n),
    .nap       (nap_active)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_conv) disable iff (!rst_s_n)
    !auto_trig_en |=> (!conv_start && eoc_n && !nap_active)); // R7

endmodule

// File: tb/sar_autotrig_seq_bench.sv
`timescale 1ns/1ps
module sar_autotrig_seq_bench;

  localparam int ACQ  = 3;
  localparam int CONV = 18;
  localparam int WAKE = 3;
  localparam int PF   = ACQ + CONV;
  localparam int PS   = 2 * PF;
  localparam int NAP_FIRST = PF + 1;
  localparam int NAP_LAST  = PS - WAKE - ACQ;

  logic clk = 1'b0;
  logic rst_n;
  logic en, rate, an;
  logic conv_start, eoc_n, nap_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  sar_autotrig_seq u_sar_autotrig_seq (
    .clk_conv      (clk),
    .rst_n         (rst_n),
    .auto_trig_en  (en),
    .rate_slow_sel (rate),
    .auto_nap_en   (an),
    .conv_start    (conv_start),
    .eoc_n         (eoc_n),
    .nap_active    (nap_active)
  );

  // Behavioural expectation, built from the requirement text.
  bit mrun  = 0;
  int mk    = 0;
  bit mslow = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrun = 0; mk = 0; mslow = 0;
    end else if (!en) begin
      mrun = 0; mk = 0;
    end else if (!mrun) begin
      mrun = 1; mk = 0; mslow = rate;
    end else if (mk == (mslow ? PS : PF) - 1) begin
      mk = 0; mslow = rate;
    end else begin
      mk++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  bit chk_on = 0;
  int gap = 0;
  bit gap_arm = 0;
  int gap_exp = 0;
  bit gap_chg = 0;
  bit nap_prev = 0;
  bit lead_arm = 0;
  int lead = 0;

  always @(negedge clk) begin
    if (chk_on) begin
      bit es, ee, en_exp;
      string ts, tn;
      es = mrun && mk == 0;
      ee = !(mrun && mk >= ACQ && mk < PF);
      en_exp = an && mslow && mrun && mk >= NAP_FIRST && mk <= NAP_LAST;
      ts = !mrun ? "R7" : (mslow ? "R2" : "R1");
      tn = !mrun ? "R7" : (!mslow ? "R6" : "R4");
      chk(conv_start == es, ts, conv_start, es);
      chk(eoc_n == ee, mrun ? "R3" : "R7", eoc_n, ee);
      chk(nap_active == en_exp, tn, nap_active, en_exp);
      if (nap_active) chk(eoc_n && !conv_start, "R4", {eoc_n, conv_start}, 2);
      // strobe spacing, against the rate latched at the period start
      if (!mrun) begin
        gap_arm = 0;
      end else if (conv_start) begin
        if (gap_arm)
          chk(gap + 1 == gap_exp, gap_chg ? "R8" : (gap_exp == PS ? "R2" : "R1"), gap + 1, gap_exp);
        gap_arm = 1; gap = 0; gap_exp = mslow ? PS : PF; gap_chg = 0;
      end else begin
        gap++;
      end
      if (mrun && rate != mslow) gap_chg = 1;
      // wake-up lead: nap release to strobe
      if (nap_prev && !nap_active && an && mrun && mslow) begin
        lead_arm = 1; lead = 0;
      end else if (lead_arm) begin
        lead++;
        if (!mrun || !an) lead_arm = 0;
        else if (conv_start) begin
          chk(lead == WAKE + ACQ - 1, "R5", lead, WAKE + ACQ - 1);
          lead_arm = 0;
        end
      end
      nap_prev = nap_active;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wait_phase(input int ph);
    for (int i = 0; i < 200; i++) begin
      if (mrun && mk == ph) return;
      step(1);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 0; en = 0; rate = 0; an = 1;
    #5;
    // R9 reset state, while reset is held
    chk(conv_start == 0, "R9", conv_start, 0);
    chk(eoc_n == 1, "R9", eoc_n, 1);
    chk(nap_active == 0, "R9", nap_active, 0);
    step(3);
    rst_n = 1;
    step(6);
    chk(conv_start == 0 && eoc_n == 1 && nap_active == 0, "R9",
        {conv_start, eoc_n, nap_active}, 3'b010);
    chk_on = 1;

    // all static mode combinations
    for (int m = 0; m < 8; m++) begin
      rate = m[0]; an = m[1]; en = m[2];
      step(130);
      en = 0;
      step(5);
    end

    // R8: flip rate at every index of a slow period, then of a fast one
    for (int ph = 0; ph < PS; ph++) begin
      en = 1; rate = 1; an = 1;
      step(PS + 2);
      wait_phase(ph);
      rate = 0;
      step(PS + 5);
      rate = 1;
      step(2 * PS);
    end
    for (int ph = 0; ph < PF; ph++) begin
      rate = 0;
      step(PS + 2);
      wait_phase(ph);
      rate = 1;
      step(2 * PS + 3);
    end

    // R4 and R7: drop auto-nap, then enable, at every index of a slow period
    for (int ph = 0; ph < PS; ph++) begin
      en = 1; rate = 1; an = 1;
      step(PS + 1);
      wait_phase(ph);
      an = 0;
      step(2);
      an = 1;
      step(PS);
      wait_phase(ph);
      en = 0;
      step(2);
      en = 1;
      step(PS + 4);
    end

    // pseudo-random mix
    lfsr = 16'hACE1;
    en = 1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[5:0] == 6'd0) en = ~en;
      if (lfsr[9:6] == 4'd3) rate = ~rate;
      if (lfsr[13:10] == 4'd7) an = ~an;
      step(1);
    end
    en = 0;
    step(4);
    chk_on = 0;
    finish_run();
  end

endmodule